// File: doc/BRIEF.md
# Sector Erase Queue with Acceptance Window

This block gathers sector erase requests for a flash array into a one-bit-per-sector selection map. The first accepted request opens an acceptance window. Every further accepted request adds its sector to the map and restarts the window. When the window runs out with no new request, the erase phase begins. During the erase phase an external erase engine works on the selected sectors and reports completion on `erase_done`.

The block also handles suspend and resume. A suspend written while the window is open stops the window at once and enters the suspended state. A suspend written during the erase phase takes effect after a fixed latency. A resume returns to the erase phase, and a later suspend is accepted again.

Reads that arrive while an erase is queued, running or suspended return a status byte. Its bits let software tell whether the window is still open, whether the erase is running, and whether a given sector is one of the selected sectors. Command strobes arrive already decoded. The window length and the suspend latency are parameters in clock cycles, so a bench can scale them down.

Top module: `sector_erase_queue`

## Requirements
- R1: After a synchronous reset the block is idle: `win_open`, `erasing`, `suspended`, `rd_vld` and `rd_is_stat` are 0, and `sel_map` is all zero.
- R2: A sector erase strobe targets sector `cmd_addr[19:16]`, and an accepted one sets that bit of `sel_map`. A strobe for a sector whose `prot_mask` bit is 1 changes nothing: it opens no window and adds no bit.
- R3: The window opens on the first accepted strobe. It stays open for WIN_CYC cycles after the most recent accepted strobe, and then `erasing` rises.
- R4: While erasing or suspended, sector erase strobes and other-command strobes leave `sel_map` and the state unchanged.
- R5: While the window is open, an other-command strobe or a resume strobe clears `sel_map` and returns the block to idle.
- R6: A suspend strobe while the window is open gives `suspended`=1 on the next cycle and keeps `sel_map`.
- R7: A suspend strobe during the erase phase gives `suspended`=1 exactly SUSP_CYC cycles later. An `erase_done` before then ends the erase instead.
- R8: A resume strobe while suspended returns the block to the erase phase, and a later suspend is accepted again.
- R9: `erase_done` during the erase phase returns the block to idle and clears `sel_map`.
- R10: A read returns its result one cycle later with `rd_vld`=1. While the window is open or the erase runs, every read returns a status byte (`rd_is_stat`=1) with these bits: bit 7 is 0; bit 3 is 0 while the window is open and 1 once erase has started; bit 6 inverts on each successive status read. All other bits are 0.
- R11: Bit 2 of the status byte inverts only on reads of selected sectors and holds on other reads. While suspended, a read of a selected sector returns bit 7=1, bit 3=1, bit 6 unchanged and bit 2 toggling. A read of an unselected sector while suspended, or any read while idle, returns `rd_is_stat`=0 and a zero byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_sect_erase | input | 1 | Decoded sector erase command strobe |
| cmd_suspend | input | 1 | Decoded erase suspend strobe |
| cmd_resume | input | 1 | Decoded erase resume strobe |
| cmd_other | input | 1 | Any other decoded command strobe |
| cmd_addr | input | AW | Address carried by the sector erase command |
| prot_mask | input | NS | Per-sector protection, 1 = protected |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| erase_done | input | 1 | Erase engine completion pulse |
| win_open | output | 1 | Acceptance window is open |
| erasing | output | 1 | Erase running (including a pending suspend) |
| suspended | output | 1 | Erase is suspended |
| sel_map | output | NS | Selected-sector bitmap |
| rd_vld | output | 1 | Read result valid |
| rd_is_stat | output | 1 | Read result is a status byte, not array data |
| rd_stat | output | 8 | Status byte |

## Verification
The assertions check on every cycle the rules that relate one cycle to the next:
- a protected sector never appears in the map;
- suspend in the window takes hold on the following cycle;
- window aborts and erase completion clear the map;
- commands during erase leave the map alone;
- a non-status read carries a zero byte.

The exact window length and its restart, the suspend latency, and the alternation of bits 6 and 2 across successive reads span many cycles. Only the bench's scenarios show them, through its cycle-by-cycle reference model.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIN,
    ST_ERASE,
    ST_SPEND,
    ST_SUSP
  } seq_state_e;
endpackage

// File: rtl/seq_cdown.sv
module seq_cdown #(
  parameter int unsigned LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(LEN - 1);
    end else if (run && cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/seq_status.sv
module seq_status
  import seq_pkg::*;
#(
  parameter int unsigned NS = 16,
  localparam int unsigned SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_stb,
  input  logic [SW-1:0] rd_sect,
  input  seq_state_e    st,
  input  logic [NS-1:0] sel_map,
  output logic          rd_vld,
  output logic          rd_is_stat,
  output logic [7:0]    rd_stat
);
  logic tog_all;
  logic tog_sel;
  logic hit;
  logic busy;

  assign hit  = sel_map[rd_sect];
  assign busy = (st == ST_WIN) || (st == ST_ERASE) || (st == ST_SPEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_all    <= 1'b0;
      tog_sel    <= 1'b0;
      rd_vld     <= 1'b0;
      rd_is_stat <= 1'b0;
      rd_stat    <= 8'h00;
    end else begin
      rd_vld     <= rd_stb;
      rd_is_stat <= 1'b0;
      rd_stat    <= 8'h00;
      if (rd_stb && busy) begin
        rd_is_stat <= 1'b1;
        rd_stat    <= {1'b0, tog_all, 2'b00, (st != ST_WIN), tog_sel, 2'b00};
        tog_all    <= ~tog_all;
        if (hit) tog_sel <= ~tog_sel;
      end else if (rd_stb && st == ST_SUSP && hit) begin
        rd_is_stat <= 1'b1;
        rd_stat    <= {1'b1, tog_all, 2'b00, 1'b1, tog_sel, 2'b00};
        tog_sel    <= ~tog_sel;
      end
    end
  end

  // R11
  data_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && !rd_is_stat) |-> (rd_stat == 8'h00));

  // R10
  idle_read_plain_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && st == ST_IDLE) |=> (rd_vld && !rd_is_stat));
endmodule

// File: rtl/sector_erase_queue.sv
module sector_erase_queue
  import seq_pkg::*;
#(
  parameter int unsigned AW       = 20,
  parameter int unsigned NS       = 16,
  parameter int unsigned WIN_CYC  = 10000000,
  parameter int unsigned SUSP_CYC = 4000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_sect_erase,
  input  logic          cmd_suspend,
  input  logic          cmd_resume,
  input  logic          cmd_other,
  input  logic [AW-1:0] cmd_addr,
  input  logic [NS-1:0] prot_mask,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  input  logic          erase_done,
  output logic          win_open,
  output logic          erasing,
  output logic          suspended,
  output logic [NS-1:0] sel_map,
  output logic          rd_vld,
  output logic          rd_is_stat,
  output logic [7:0]    rd_stat
);
  localparam int unsigned SW = $clog2(NS);

  seq_state_e    st, nxt;
  logic [SW-1:0] cmd_sect;
  logic [SW-1:0] rd_sect;
  logic          sect_ok;
  logic          add_en;
  logic          win_load, win_exp;
  logic          sus_load, sus_exp;
  logic          clr_map;
  logic [NS-1:0] set_vec;
  logic          unused_addr_bits;

  assign cmd_sect = cmd_addr[AW-1 -: SW];
  assign rd_sect  = rd_addr[AW-1 -: SW];
  assign sect_ok  = cmd_sect_erase && !prot_mask[cmd_sect];
  assign unused_addr_bits = ^{cmd_addr[AW-SW-1:0], rd_addr[AW-SW-1:0]};

  always_comb begin
    nxt      = st;
    add_en   = 1'b0;
    win_load = 1'b0;
    sus_load = 1'b0;
    case (st)
      ST_IDLE: begin
        if (sect_ok) begin
          nxt      = ST_WIN;
          add_en   = 1'b1;
          win_load = 1'b1;
        end
      end
      ST_WIN: begin
        if (cmd_other || cmd_resume) begin
          nxt = ST_IDLE;
        end else if (cmd_suspend) begin
          nxt = ST_SUSP;
        end else if (sect_ok) begin
          add_en   = 1'b1;
          win_load = 1'b1;
        end else if (win_exp) begin
          nxt = ST_ERASE;
        end
      end
      ST_ERASE: begin
        if (erase_done) begin
          nxt = ST_IDLE;
        end else if (cmd_suspend) begin
          nxt      = ST_SPEND;
          sus_load = 1'b1;
        end
      end
      ST_SPEND: begin
        if (erase_done) nxt = ST_IDLE;
        else if (sus_exp) nxt = ST_SUSP;
      end
      ST_SUSP: begin
        if (cmd_resume) nxt = ST_ERASE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign clr_map = (nxt == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end

  for (genvar s = 0; s < NS; s++) begin : g_sel
    assign set_vec[s] = add_en && (cmd_sect == SW'(s));
  end

  always_ff @(posedge clk) begin
    if (rst || clr_map) sel_map <= '0;
    else                sel_map <= sel_map | set_vec;
  end

  seq_cdown #(.LEN(WIN_CYC)) u_win (
    .clk(clk), .rst(rst), .load(win_load),
    .run(st == ST_WIN), .expired(win_exp)
  );

  seq_cdown #(.LEN(SUSP_CYC)) u_sus (
    .clk(clk), .rst(rst), .load(sus_load),
    .run(st == ST_SPEND), .expired(sus_exp)
  );

  seq_status #(.NS(NS)) u_stat (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_sect(rd_sect),
    .st(st), .sel_map(sel_map),
    .rd_vld(rd_vld), .rd_is_stat(rd_is_stat), .rd_stat(rd_stat)
  );

  assign win_open  = (st == ST_WIN);
  assign erasing   = (st == ST_ERASE) || (st == ST_SPEND);
  assign suspended = (st == ST_SUSP);

  // R2
  prot_never_added_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_map & ~$past(sel_map) & $past(prot_mask)) == '0);

  // R6
  win_suspend_chk: assert property (@(posedge clk) disable iff (rst)
    (win_open && cmd_suspend && !cmd_other && !cmd_resume) |=> (suspended && $stable(sel_map)));

  // R5
  win_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (win_open && cmd_other) |=> (!win_open && !erasing && !suspended && sel_map == '0));

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (erasing && erase_done) |=> (!erasing && !suspended && sel_map == '0));

  // R4
  erase_map_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((erasing || suspended) && !erase_done) |=> $stable(sel_map));
endmodule

// File: tb/test_sector_erase_queue.sv
`timescale 1ns/1ps
module test_sector_erase_queue;
  localparam int WIN = 40;
  localparam int SL  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_sect_erase = 0, cmd_suspend = 0, cmd_resume = 0, cmd_other = 0;
  logic [19:0] cmd_addr = '0;
  logic [15:0] prot_mask = '0;
  logic        rd_stb = 0;
  logic [19:0] rd_addr = '0;
  logic        erase_done = 0;
  logic        win_open, erasing, suspended, rd_vld, rd_is_stat;
  logic [15:0] sel_map;
  logic [7:0]  rd_stat;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sector_erase_queue #(.AW(20), .NS(16), .WIN_CYC(WIN), .SUSP_CYC(SL)) i_sector_erase_queue (
    .clk(clk), .rst(rst), .cmd_sect_erase(cmd_sect_erase), .cmd_suspend(cmd_suspend),
    .cmd_resume(cmd_resume), .cmd_other(cmd_other), .cmd_addr(cmd_addr),
    .prot_mask(prot_mask), .rd_stb(rd_stb), .rd_addr(rd_addr), .erase_done(erase_done),
    .win_open(win_open), .erasing(erasing), .suspended(suspended), .sel_map(sel_map),
    .rd_vld(rd_vld), .rd_is_stat(rd_is_stat), .rd_stat(rd_stat)
  );

  // reference model: 0 idle, 1 window, 2 erase, 3 suspend pending, 4 suspended
  int       mst, wleft, sleft;
  bit [15:0] mmap;
  bit       m6, m2, mvld, mis, hitv, good;
  bit [7:0] mstat;
  int       sec;

  always @(posedge clk) begin
    if (rst) begin
      mst = 0; wleft = 0; sleft = 0; mmap = 0; m6 = 0; m2 = 0;
      mvld = 0; mis = 0; mstat = 0;
    end else begin
      mvld = rd_stb; mis = 0; mstat = 0;
      if (rd_stb) begin
        hitv = mmap[rd_addr[19:16]];
        if (mst == 1 || mst == 2 || mst == 3) begin
          mis = 1; mstat[6] = m6; mstat[3] = (mst != 1); mstat[2] = m2;
          m6 = !m6;
          if (hitv) m2 = !m2;
        end else if (mst == 4 && hitv) begin
          mis = 1; mstat[7] = 1; mstat[6] = m6; mstat[3] = 1; mstat[2] = m2;
          m2 = !m2;
        end
      end
      sec  = int'(cmd_addr[19:16]);
      good = cmd_sect_erase && !prot_mask[sec];
      case (mst)
        0: if (good) begin mmap = 16'h0; mmap[sec] = 1; mst = 1; wleft = WIN; end
        1: begin
          if (cmd_other || cmd_resume) begin mst = 0; mmap = 0; end
          else if (cmd_suspend) mst = 4;
          else if (good) begin mmap[sec] = 1; wleft = WIN; end
          else begin wleft--; if (wleft == 0) mst = 2; end
        end
        2: begin
          if (erase_done) begin mst = 0; mmap = 0; end
          else if (cmd_suspend) begin mst = 3; sleft = SL; end
        end
        3: begin
          if (erase_done) begin mst = 0; mmap = 0; end
          else begin sleft--; if (sleft == 0) mst = 4; end
        end
        4: if (cmd_resume) mst = 2;
        default: mst = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      total++;
      if ({win_open, erasing, suspended} !== {mst == 1, mst == 2 || mst == 3, mst == 4}) begin
        bad++;
        $display("FAIL R3 state flags act=%b exp=%b", {win_open, erasing, suspended},
                 {mst == 1, mst == 2 || mst == 3, mst == 4});
      end
      total++;
      if (sel_map !== mmap) begin
        bad++;
        $display("FAIL R2 sel_map act=%h exp=%h", sel_map, mmap);
      end
      total++;
      if ({rd_vld, rd_is_stat, rd_stat} !== {mvld, mis, mstat}) begin
        bad++;
        $display("FAIL R10 read act=%b/%b/%h exp=%b/%b/%h", rd_vld, rd_is_stat, rd_stat,
                 mvld, mis, mstat);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sect(input logic [19:0] a);
    cmd_sect_erase = 1; cmd_addr = a; @(negedge clk); cmd_sect_erase = 0;
  endtask

  task automatic susp();
    cmd_suspend = 1; @(negedge clk); cmd_suspend = 0;
  endtask

  task automatic resm();
    cmd_resume = 1; @(negedge clk); cmd_resume = 0;
  endtask

  task automatic other();
    cmd_other = 1; @(negedge clk); cmd_other = 0;
  endtask

  task automatic done();
    erase_done = 1; @(negedge clk); erase_done = 0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [7:0] s, output logic is);
    rd_stb = 1; rd_addr = a; @(negedge clk); rd_stb = 0;
    s = rd_stat; is = rd_is_stat;
  endtask

  logic [7:0] a, b, c, d, e, f, g, h;
  logic ia, ib, ic, id, ie, iff_, ig, ih;

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 flags", {win_open, erasing, suspended, rd_vld, rd_is_stat}, 0);
    chk("R1 map", sel_map, 0);
    prot_mask = 16'h0080;

    sect(20'h31234);
    chk("R2 first sector", sel_map, 16'h0008);
    chk("R3 window open", win_open, 1);
    rd(20'h30000, a, ia);
    rd(20'h30000, b, ib);
    chk("R10 window status", {ia, a[7], a[3]}, 3'b100);
    chk("R10 bit6 toggles", a[6] ^ b[6], 1);
    chk("R11 bit2 toggles selected", a[2] ^ b[2], 1);
    idle(5);
    sect(20'h90000);
    chk("R2 second sector", sel_map, 16'h0208);
    idle(WIN - 1);
    chk("R3 still open", win_open, 1);
    idle(1);
    chk("R3 erase started", {win_open, erasing}, 2'b01);

    rd(20'h50000, c, ic);
    rd(20'h50000, d, id);
    chk("R11 bit2 holds unselected", c[2] ^ d[2], 0);
    chk("R10 erase status", {ic, c[7], c[3]}, 3'b101);
    chk("R10 bit6 toggles erase", c[6] ^ d[6], 1);
    sect(20'h50000);
    chk("R4 map held", sel_map, 16'h0208);
    other();
    chk("R4 other ignored", erasing, 1);

    susp();
    idle(SL - 1);
    chk("R7 not yet suspended", {erasing, suspended}, 2'b10);
    idle(1);
    chk("R7 suspended", {erasing, suspended}, 2'b01);
    rd(20'h30000, e, ie);
    rd(20'h30000, f, iff_);
    chk("R11 suspend status", {ie, e[7], e[3]}, 3'b111);
    chk("R11 bit6 frozen", e[6] ^ f[6], 0);
    chk("R11 bit2 toggles suspend", e[2] ^ f[2], 1);
    rd(20'h50000, g, ig);
    chk("R11 unselected data", {ig, g}, 9'h000);

    resm();
    chk("R8 resumed", {erasing, suspended}, 2'b10);
    susp();
    idle(2);
    done();
    chk("R7 done before suspend", {win_open, erasing, suspended}, 0);
    chk("R9 map cleared", sel_map, 0);

    sect(20'h7abcd);
    chk("R2 protected ignored", {win_open, sel_map}, 0);

    sect(20'h10000);
    other();
    chk("R5 other aborts", {win_open, sel_map}, 0);
    sect(20'h10000);
    resm();
    chk("R5 resume aborts", {win_open, sel_map}, 0);

    sect(20'h20000);
    susp();
    chk("R6 window suspend", {suspended, sel_map}, {1'b1, 16'h0004});
    resm();
    chk("R8 resume to erase", erasing, 1);
    idle(3);
    done();
    chk("R9 idle after done", {erasing, sel_map}, 0);
    rd(20'h20000, h, ih);
    chk("R11 idle read data", {ih, h}, 9'h000);

    idle(5);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule